// File: doc/BRIEF.md
# Saturating rounding narrowing interleaver

This block is a vector datapath stage. It takes two source vectors made of signed 32-bit lanes and a shift immediate. Each lane is rounded to nearest, with ties rounded up, by adding half of the shift step. The lane is then shifted right arithmetically and clamped into the unsigned 16-bit range. The two groups of narrowed results are merged into one destination vector of 16-bit lanes, alternating between the sources rather than placing one group after the other. The arithmetic runs at 34-bit signed precision, so adding the bias to the largest positive input cannot wrap.

The vector width is a parameter. The operands and the immediate are accepted whenever `valid_in` is high. The result is registered and presented with `valid_out` on the next cycle. The output stage is a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` means the registered result is valid for this cycle. Transition `T_ACCEPT` moves either state to `ST_EMIT` when `valid_in` is high. Transition `T_DRAIN` moves either state to `ST_IDLE` when `valid_in` is low. An immediate outside 1..16 is clamped into range and flagged.

Top module: `satnarrow_ilv`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `valid_out` is 0, `shift_err` is 0 and `dst` is all zeros.
- R2: `valid_out` is high in exactly those cycles that directly follow a rising clock edge at which `valid_in` was high.
- R3: For a non-negative lane value e and an effective shift s, the narrowed value is floor((e + 2^(s-1)) / 2^s), computed without overflow. For example, 0x7FFFFFFF with s = 16 gives 0x8000 before clamping.
- R4: A source lane whose bit 31 is set (a negative value) produces output lane value 0x0000.
- R5: A narrowed value above 0xFFFF produces output lane value 0xFFFF. Any other value is passed on as its low 16 bits.
- R6: Source lane k occupies bits [32k+31:32k]. Output lane j occupies bits [16j+15:16j]. Output lane 2k comes from lane k of `src_a`, and output lane 2k+1 comes from lane k of `src_b`.
- R7: An immediate of 0 is applied as shift 1, and an immediate of 17..31 is applied as shift 16. `shift_err` is high together with `valid_out` exactly when the accepted immediate was outside 1..16.
- R8: In a cycle where `valid_out` is low, `dst` keeps its previous value and `shift_err` is 0.
- R9: `VEC_BITS` may be 128, 256, 512, 1024 or 2048. Each source then holds VEC_BITS/32 lanes and the destination holds VEC_BITS/16 lanes, and every lane follows the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands and immediate are presented this cycle |
| src_a | input | VEC_BITS | First source vector; feeds the even output lanes |
| src_b | input | VEC_BITS | Second source vector; feeds the odd output lanes |
| shift_imm | input | 5 | Shift immediate; the legal range is 1..16 |
| valid_out | output | 1 | `dst` holds a new result this cycle |
| dst | output | VEC_BITS | Interleaved narrowed result |
| shift_err | output | 1 | The presented result used a clamped immediate |

## Verification
The bench builds the block with `VEC_BITS` = 256. This gives eight lanes per source, enough to place a full set of corner values into one transaction and to check that every even/odd lane position is interleaved correctly.

Every immediate from 0 to 20 is applied, which covers all legal shifts and both clamp directions. The inputs include the rounding-boundary values just below and just above each tie point, values on both sides of the saturation edge, the extreme positive and negative values, and -1. Random operands are then sent both back to back and with idle gaps, which exercises both state transitions and the hold behaviour.

// File: rtl/satn_pkg.sv
package satn_pkg;
    localparam int SRC_W   = 32;
    localparam int DST_W   = 16;
    localparam int IMM_W   = 5;
    localparam int SH_MIN  = 1;
    localparam int SH_MAX  = 16;
    localparam int WIDE_W  = SRC_W + 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;
endpackage

// File: rtl/satn_shift_clamp.sv
module satn_shift_clamp
    import satn_pkg::*;
(
    input  logic [IMM_W-1:0] imm_raw,
    output logic [IMM_W-1:0] imm_eff,
    output logic             imm_bad
);
    always_comb begin
        if (imm_raw < IMM_W'(SH_MIN)) begin
            imm_eff = IMM_W'(SH_MIN);
            imm_bad = 1'b1;
        end else if (imm_raw > IMM_W'(SH_MAX)) begin
            imm_eff = IMM_W'(SH_MAX);
            imm_bad = 1'b1;
        end else begin
            imm_eff = imm_raw;
            imm_bad = 1'b0;
        end
    end

    // R7: the effective shift always lies in the legal range
    always_comb begin
        a_imm_range_r7: assert (imm_eff >= IMM_W'(SH_MIN) && imm_eff <= IMM_W'(SH_MAX))
            else $error("effective shift out of range");
    end
endmodule

// File: rtl/satn_lane.sv
module satn_lane
    import satn_pkg::*;
(
    input  logic [SRC_W-1:0] lane_in,
    input  logic [IMM_W-1:0] sh,
    output logic [DST_W-1:0] lane_out
);
    logic signed [WIDE_W-1:0] widened;
    logic signed [WIDE_W-1:0] bias;
    logic signed [WIDE_W-1:0] biased;
    logic signed [WIDE_W-1:0] shifted;
    logic                     over;

    always_comb begin
        widened = {{(WIDE_W-SRC_W){lane_in[SRC_W-1]}}, lane_in};
        bias    = WIDE_W'(1) << (sh - IMM_W'(1));
        biased  = widened + bias;
        shifted = biased >>> sh;
        over    = |shifted[WIDE_W-1:DST_W];
        if (lane_in[SRC_W-1]) begin
            lane_out = '0;
        end else if (over) begin
            lane_out = '1;
        end else begin
            lane_out = shifted[DST_W-1:0];
        end
    end
endmodule

// File: rtl/satn_out_stage.sv
module satn_out_stage
    import satn_pkg::*;
#(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] next_dst,
    input  logic         next_err,
    output logic         valid_out,
    output logic [W-1:0] dst,
    output logic         shift_err
);
    emit_state_t state_q, state_d;
    logic [W-1:0] dst_q;
    logic         err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_EMIT : ST_IDLE;   // T_ACCEPT / stay
            ST_EMIT: state_d = take ? ST_EMIT : ST_IDLE;   // T_ACCEPT / T_DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            err_q <= 1'b0;
        end else if (take) begin
            dst_q <= next_dst;
            err_q <= next_err;
        end
    end

    assign valid_out = (state_q == ST_EMIT);
    assign dst       = dst_q;
    assign shift_err = err_q & valid_out;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> valid_out) else $error("valid_out missing");
    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !valid_out) else $error("spurious valid_out");
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(dst)) else $error("dst changed while idle");
    p_err_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_err |-> valid_out) else $error("shift_err without valid_out");
endmodule

// File: rtl/satnarrow_ilv.sv
module satnarrow_ilv
    import satn_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [VEC_BITS-1:0] src_a,
    input  logic [VEC_BITS-1:0] src_b,
    input  logic [IMM_W-1:0]    shift_imm,
    output logic                valid_out,
    output logic [VEC_BITS-1:0] dst,
    output logic                shift_err
);
    localparam int SRC_LANES = VEC_BITS / SRC_W;
    localparam int DST_LANES = VEC_BITS / DST_W;

    // R9: legal vector widths only
    initial begin
        a_vec_bits_r9: assert (VEC_BITS == 128 || VEC_BITS == 256 || VEC_BITS == 512 ||
                               VEC_BITS == 1024 || VEC_BITS == 2048)
            else $error("unsupported VEC_BITS");
        a_lane_ratio_r9: assert (DST_LANES == 2 * SRC_LANES)
            else $error("lane count mismatch");
    end

    logic [IMM_W-1:0]    sh_eff;
    logic                sh_bad;
    logic [VEC_BITS-1:0] merged;

    satn_shift_clamp u_clamp (
        .imm_raw (shift_imm),
        .imm_eff (sh_eff),
        .imm_bad (sh_bad)
    );

    for (genvar k = 0; k < SRC_LANES; k++) begin : g_lane
        logic [DST_W-1:0] even_res;
        logic [DST_W-1:0] odd_res;

        satn_lane u_even (
            .lane_in  (src_a[SRC_W*k +: SRC_W]),
            .sh       (sh_eff),
            .lane_out (even_res)
        );
        satn_lane u_odd (
            .lane_in  (src_b[SRC_W*k +: SRC_W]),
            .sh       (sh_eff),
            .lane_out (odd_res)
        );

        // R6: interleave, even lane from src_a, odd lane from src_b
        assign merged[DST_W*(2*k)   +: DST_W] = even_res;
        assign merged[DST_W*(2*k+1) +: DST_W] = odd_res;

        p_neg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && src_b[SRC_W*k + SRC_W-1]) |=> (dst[DST_W*(2*k+1) +: DST_W] == '0))
            else $error("negative lane not zero");
    end

    satn_out_stage #(.W(VEC_BITS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (valid_in),
        .next_dst  (merged),
        .next_err  (sh_bad),
        .valid_out (valid_out),
        .dst       (dst),
        .shift_err (shift_err)
    );

    p_err_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (shift_imm == '0)) |=> shift_err)
        else $error("zero immediate not flagged");
endmodule

// File: tb/satnarrow_ilv_bench.sv
module satnarrow_ilv_bench;
    localparam int VB    = 256;
    localparam int NL    = VB / 32;

    typedef struct {
        logic [VB-1:0] d;
        logic          e;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [VB-1:0] src_a = '0;
    logic [VB-1:0] src_b = '0;
    logic [4:0]    shift_imm = 5'd1;
    logic          valid_out;
    logic [VB-1:0] dst;
    logic          shift_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];
    logic [VB-1:0] last_dst = '0;

    always #5 clk = ~clk;

    satnarrow_ilv #(.VEC_BITS(VB)) u_satnarrow_ilv (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .src_a(src_a), .src_b(src_b), .shift_imm(shift_imm),
        .valid_out(valid_out), .dst(dst), .shift_err(shift_err)
    );

    function automatic logic [15:0] ref_lane(logic [31:0] e, int s);
        longint v;
        if (e[31]) return 16'h0000;
        v = (longint'(e) + (longint'(1) << (s - 1))) >>> s;
        if (v > 65535) return 16'hFFFF;
        return v[15:0];
    endfunction

    function automatic logic [31:0] corner(int idx, int s);
        int m;
        m = 37 + s * 11;
        case (idx % 16)
            0:  return 32'h7FFF_FFFF;
            1:  return 32'h8000_0000;
            2:  return 32'hFFFF_FFFF;
            3:  return 32'h0000_0000;
            4:  return 32'((m << s) - (1 << (s - 1)));
            5:  return 32'((m << s) - (1 << (s - 1)) - 1);
            6:  return 32'((1 << (s - 1)));
            7:  return 32'((1 << (s - 1)) - 1);
            8:  return 32'((longint'(65536) << s) - (longint'(1) << (s - 1)) - 1);
            9:  return 32'((longint'(65536) << s) - (longint'(1) << (s - 1)));
            10: return 32'h0001_0000;
            11: return 32'hFFFF_8000;
            12: return 32'((m << s) + (1 << (s - 1)));
            13: return 32'((m << s) + (1 << (s - 1)) - 1);
            14: return 32'h0000_FFFF;
            default: return 32'h4000_0001;
        endcase
    endfunction

    task automatic send(input logic [VB-1:0] a, input logic [VB-1:0] b,
                        input logic [4:0] imm, input string tag);
        exp_t x;
        int s;
        s = (imm < 1) ? 1 : ((imm > 16) ? 16 : int'(imm));
        for (int k = 0; k < NL; k++) begin
            x.d[32*k      +: 16] = ref_lane(a[32*k +: 32], s);
            x.d[32*k + 16 +: 16] = ref_lane(b[32*k +: 32], s);
        end
        x.e   = (imm < 1) || (imm > 16);
        x.tag = tag;
        @(negedge clk);
        src_a = a; src_b = b; shift_imm = imm; valid_in = 1'b1;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            src_a = {NL{32'hDEAD_BEEF}};
        end
    endtask

    // monitor / scoreboard
    initial begin
        exp_t x;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            #1;
            if (valid_out) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R2: valid_out=1 with no pending item, expected 0");
                end else begin
                    x = q.pop_front();
                    if (dst !== x.d || shift_err !== x.e) begin
                        fails++;
                        $display("FAIL %s: dst=%h err=%b expected dst=%h err=%b",
                                 x.tag, dst, shift_err, x.d, x.e);
                    end
                end
                last_dst = dst;
            end else begin
                checks++;
                if (dst !== last_dst || shift_err !== 1'b0) begin
                    fails++;
                    $display("FAIL R8: idle dst=%h err=%b expected dst=%h err=0",
                             dst, shift_err, last_dst);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [VB-1:0] a, b;
        repeat (3) @(negedge clk);
        checks++;
        if (valid_out !== 1'b0 || shift_err !== 1'b0 || dst !== '0) begin
            fails++;
            $display("FAIL R1: in reset valid=%b err=%b dst=%h expected 0 0 0",
                     valid_out, shift_err, dst);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (valid_out !== 1'b0 || dst !== '0) begin
            fails++;
            $display("FAIL R1: after release valid=%b dst=%h expected 0 0", valid_out, dst);
        end

        // R3 R4 R5 R6 R7: corners for every immediate 0..20
        for (int imm = 0; imm <= 20; imm++) begin
            int s;
            s = (imm < 1) ? 1 : ((imm > 16) ? 16 : imm);
            for (int k = 0; k < NL; k++) begin
                a[32*k +: 32] = corner(2*k, s);
                b[32*k +: 32] = corner(2*k + 1, s);
            end
            send(a, b, 5'(imm), "R3_R4_R5_R6_R7 corners");
            if (imm % 3 == 0) idle(1);
            for (int k = 0; k < NL; k++) begin
                a[32*k +: 32] = corner(2*k + 1, s);
                b[32*k +: 32] = corner(2*k, s);
            end
            send(a, b, 5'(imm), "R6 swapped corners");
        end
        idle(2);

        // R6: distinct lanes to expose interleave order
        for (int k = 0; k < NL; k++) begin
            a[32*k +: 32] = 32'((k + 1) << 8);
            b[32*k +: 32] = 32'((k + 101) << 8);
        end
        send(a, b, 5'd8, "R6 lane order");
        idle(2);

        // R9 random traffic with gaps
        for (int t = 0; t < 300; t++) begin
            for (int k = 0; k < NL; k++) begin
                a[32*k +: 32] = $urandom;
                b[32*k +: 32] = $urandom >> ($urandom % 32);
            end
            send(a, b, 5'($urandom % 32), "R9 random");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(3);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results never produced, expected 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule